// File: doc/BRIEF.md
# Drive Power-Mode Controller

This block holds the power state of a disk drive (Active, Idle, Standby or Sleep) and moves between these states in response to power-management command codes, media-access demands, a drive reset and an automatic standby countdown. A register-decode front end presents each command as a one-cycle strobe with its 8-bit code and the current sector-count value. The block answers each power command with a one-cycle busy phase followed by a one-cycle interrupt request. The interrupt is raised as soon as the new mode is recorded, even if spindle spin-up is still in progress.

The standby countdown runs on a once-per-second tick input, so a bench can shorten time by pulsing the tick faster. The countdown length is the programmed count multiplied by a unit length, which defaults to five seconds. While the drive is Active or Idle, ordinary traffic restarts the countdown. When it runs out, the drive drops to Standby. A media-access request wakes the drive from Standby and raises a spin-up request that stays high until the motor side reports completion. Sleep ignores everything except the drive reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst` the mode is Active (encoding 0), `busy`, `irq`, `spin_req` and `cnt_vld` are low, and the standby countdown is disabled.
- R2: Mode encodings are Active=0, Idle=1, Standby=2, Sleep=3. The command codes are: E0h enters Standby, E1h and F8h both enter Idle, E3h enters Idle and programs the countdown, E6h enters Sleep, F9h enters Active, and E5h queries the mode. Any other code is not a power command.
- R3: An accepted power command sets `busy` in the cycle after the strobe. In the following cycle `busy` is low and `irq` is high for exactly one cycle. A non-power command never raises `busy` or `irq`.
- R4: E3h with a nonzero sector count N starts a countdown of N*5 ticks. On the tick that ends it, the mode becomes Standby, and no interrupt is raised.
- R5: E3h with a sector count of zero disables the countdown, so the mode stays Idle however many ticks arrive.
- R6: A non-power command accepted in Active or Idle restarts the countdown from its full programmed length.
- R7: `media_req` in Standby moves the mode to Active and raises `spin_req`. `spin_req` stays high until `spin_done`. `media_req` in Idle moves the mode to Active without a spin-up request.
- R8: F9h moves the mode to Active. It raises `spin_req` only when issued from Standby. The interrupt for this command arrives while `spin_req` is still high.
- R9: In Sleep, commands and `media_req` are ignored: the mode holds and `busy` and `irq` stay low. `drv_reset` returns the mode to Active with `spin_req` high.
- R10: E5h returns 00h on `cnt_o` when the mode is Idle and FFh otherwise. `cnt_vld` is high in the same cycle as that command's `irq`.
- R11: A non-power command accepted on the very tick that would end the countdown wins: the mode stays Idle and the countdown restarts.
- R12: A command strobe that arrives while `busy` is high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 8 | Command code written by the host |
| sect_cnt | input | 8 | Sector-count register value |
| media_req | input | 1 | Media access needed |
| drv_reset | input | 1 | Hardware or software drive reset |
| tick_1s | input | 1 | One pulse per second of countdown |
| spin_done | input | 1 | Spindle is up to speed |
| spin_req | output | 1 | Spin-up requested |
| mode | output | 2 | Current power mode |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Command-complete interrupt request |
| cnt_o | output | 8 | Mode-query result |
| cnt_vld | output | 1 | `cnt_o` valid |

## Verification
The countdown expiry and command acceptance can land in the same cycle. The bench provokes this by programming a one-unit countdown, letting four ticks pass, and then driving the fifth tick in the same cycle as an ordinary command strobe. It judges the outcome by seeing Idle held after that edge, then seeing Standby only after a further full five ticks. A second overlap comes from a strobe during the busy cycle, which is judged by the mode that results.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE  = 2'd0,
        PM_IDLE    = 2'd1,
        PM_STANDBY = 2'd2,
        PM_SLEEP   = 2'd3
    } pm_mode_e;

    typedef enum logic [2:0] {
        PC_OTHER,
        PC_STBY_NOW,
        PC_IDLE_NOW,
        PC_IDLE_TMR,
        PC_SLEEP,
        PC_CHECK,
        PC_READY
    } pm_cls_e;

    localparam logic [7:0] OP_STBY_NOW  = 8'hE0;
    localparam logic [7:0] OP_IDLE_NOW  = 8'hE1;
    localparam logic [7:0] OP_IDLE_ALT  = 8'hF8;
    localparam logic [7:0] OP_IDLE_TMR  = 8'hE3;
    localparam logic [7:0] OP_SLEEP     = 8'hE6;
    localparam logic [7:0] OP_CHECK     = 8'hE5;
    localparam logic [7:0] OP_READY     = 8'hF9;

    typedef struct packed {
        logic clr;
        logic run;
        logic load;
        logic reload;
    } tmr_ctl_t;

    function automatic pm_cls_e classify(input logic [7:0] code);
        case (code)
            OP_STBY_NOW:             return PC_STBY_NOW;
            OP_IDLE_NOW, OP_IDLE_ALT: return PC_IDLE_NOW;
            OP_IDLE_TMR:             return PC_IDLE_TMR;
            OP_SLEEP:                return PC_SLEEP;
            OP_CHECK:                return PC_CHECK;
            OP_READY:                return PC_READY;
            default:                 return PC_OTHER;
        endcase
    endfunction

    function automatic logic is_awake(input pm_mode_e m);
        return (m == PM_ACTIVE) || (m == PM_IDLE);
    endfunction

endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
    import pwr_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code,
    output pm_cls_e           cls
);
    logic [7:0] code8;

    generate
        if (CODE_W >= 8) begin : g_trunc
            assign code8 = code[7:0];
            if (CODE_W > 8) begin : g_hi
                logic hi_zero;
                assign hi_zero = (code[CODE_W-1:8] == '0);
                assign cls = hi_zero ? classify(code8) : PC_OTHER;
            end else begin : g_eq
                assign cls = classify(code8);
            end
        end else begin : g_ext
            assign code8 = {{(8-CODE_W){1'b0}}, code};
            assign cls = classify(code8);
        end
    endgenerate
endmodule

// File: rtl/pwr_standby_timer.sv
module pwr_standby_timer
    import pwr_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int SEC_PER_UNIT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_ctl_t         ctl,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    localparam int MAX_SEC = ((1 << CNT_W) - 1) * SEC_PER_UNIT;
    localparam int SEC_W   = $clog2(MAX_SEC + 1);

    logic [SEC_W-1:0] period_q;
    logic [SEC_W-1:0] left_q;
    logic             en_q;
    logic [SEC_W-1:0] load_sec;

    assign load_sec = SEC_W'(load_val) * SEC_W'(SEC_PER_UNIT);

    assign expire = tick && ctl.run && en_q && (left_q == SEC_W'(1))
                    && !ctl.reload && !ctl.load && !ctl.clr;

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            period_q <= '0;
            left_q   <= '0;
            en_q     <= 1'b0;
        end else if (ctl.load) begin
            period_q <= load_sec;
            left_q   <= load_sec;
            en_q     <= (load_val != '0);
        end else if (ctl.reload) begin
            left_q   <= period_q;
        end else if (tick && ctl.run && en_q && left_q != '0) begin
            left_q   <= left_q - SEC_W'(1);
        end
    end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  pm_cls_e          cls,
    input  logic             media_req,
    input  logic             drv_reset,
    input  logic             spin_done,
    input  logic             expire,
    output tmr_ctl_t         tctl,
    output pm_mode_e         mode_q,
    output logic             busy_q,
    output logic             irq_q,
    output logic             spin_q,
    output logic [CNT_W-1:0] chk_q,
    output logic             chk_vld_q
);
    logic accept, pwr_acc, mode_chg, awake;
    logic pend_q;

    pm_mode_e         mode_d;
    logic             busy_d, irq_d, spin_d, chk_vld_d, pend_d;
    logic [CNT_W-1:0] chk_d;

    // Acceptance and timer control, kept apart from the next-state logic
    always_comb begin
        awake    = is_awake(mode_q);
        accept   = cmd_valid && !busy_q && (mode_q != PM_SLEEP);
        pwr_acc  = accept && (cls != PC_OTHER);
        mode_chg = pwr_acc && (cls != PC_CHECK);
        tctl.clr    = drv_reset;
        tctl.run    = awake;
        tctl.load   = pwr_acc && (cls == PC_IDLE_TMR);
        tctl.reload = (accept && (cls == PC_OTHER) && awake)
                    || (media_req && (mode_q != PM_SLEEP) && !mode_chg)
                    || (pwr_acc && (cls == PC_IDLE_NOW || cls == PC_READY));
    end

    always_comb begin
        mode_d    = mode_q;
        spin_d    = spin_q && !spin_done;
        busy_d    = pwr_acc;
        irq_d     = busy_q;
        chk_vld_d = busy_q && pend_q;
        pend_d    = pwr_acc && (cls == PC_CHECK);
        chk_d     = chk_q;

        if (pwr_acc && cls == PC_CHECK)
            chk_d = (mode_q == PM_IDLE) ? '0 : '1;

        if (mode_chg) begin
            case (cls)
                PC_STBY_NOW: begin
                    mode_d = PM_STANDBY;
                    spin_d = 1'b0;
                end
                PC_SLEEP: begin
                    mode_d = PM_SLEEP;
                    spin_d = 1'b0;
                end
                PC_IDLE_NOW, PC_IDLE_TMR: begin
                    if (mode_q == PM_STANDBY) spin_d = 1'b1;
                    mode_d = PM_IDLE;
                end
                PC_READY: begin
                    if (mode_q == PM_STANDBY) spin_d = 1'b1;
                    mode_d = PM_ACTIVE;
                end
                default: mode_d = mode_q;
            endcase
        end else if (media_req && mode_q != PM_SLEEP) begin
            if (mode_q == PM_STANDBY) spin_d = 1'b1;
            mode_d = PM_ACTIVE;
        end else if (expire) begin
            mode_d = PM_STANDBY;
            spin_d = 1'b0;
        end

        if (drv_reset) begin
            spin_d    = (mode_q == PM_SLEEP) || (mode_q == PM_STANDBY);
            mode_d    = PM_ACTIVE;
            busy_d    = 1'b0;
            irq_d     = 1'b0;
            chk_vld_d = 1'b0;
            pend_d    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= PM_ACTIVE;
            busy_q    <= 1'b0;
            irq_q     <= 1'b0;
            spin_q    <= 1'b0;
            chk_q     <= '0;
            chk_vld_q <= 1'b0;
            pend_q    <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            busy_q    <= busy_d;
            irq_q     <= irq_d;
            spin_q    <= spin_d;
            chk_q     <= chk_d;
            chk_vld_q <= chk_vld_d;
            pend_q    <= pend_d;
        end
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_pkg::*;
#(
    parameter int CODE_W       = 8,
    parameter int CNT_W        = 8,
    parameter int SEC_PER_UNIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [CNT_W-1:0]  sect_cnt,
    input  logic              media_req,
    input  logic              drv_reset,
    input  logic              tick_1s,
    input  logic              spin_done,
    output logic              spin_req,
    output logic [1:0]        mode,
    output logic              busy,
    output logic              irq,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              cnt_vld
);
    pm_cls_e  cls;
    tmr_ctl_t tctl;
    logic     expire;
    pm_mode_e mode_q;

    pwr_cmd_decode #(.CODE_W(CODE_W)) i_dec (
        .code (cmd_code),
        .cls  (cls)
    );

    pwr_standby_timer #(.CNT_W(CNT_W), .SEC_PER_UNIT(SEC_PER_UNIT)) i_tmr (
        .clk      (clk),
        .rst      (rst),
        .ctl      (tctl),
        .load_val (sect_cnt),
        .tick     (tick_1s),
        .expire   (expire)
    );

    pwr_mode_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cls       (cls),
        .media_req (media_req),
        .drv_reset (drv_reset),
        .spin_done (spin_done),
        .expire    (expire),
        .tctl      (tctl),
        .mode_q    (mode_q),
        .busy_q    (busy),
        .irq_q     (irq),
        .spin_q    (spin_req),
        .chk_q     (cnt_o),
        .chk_vld_q (cnt_vld)
    );

    assign mode = mode_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       media_req,
    input logic       drv_reset,
    input logic       tick_1s,
    input logic       spin_done,
    input logic [1:0] mode,
    input logic       busy,
    input logic       irq,
    input logic       spin_req,
    input logic       cnt_vld
);
    // R3
    busy_then_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !drv_reset) |=> (irq && !busy));

    // R3
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R12
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid && !drv_reset) |=> !busy);

    // R9
    sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3 && !drv_reset) |=> (mode == 2'd3 && !busy));

    // R9
    reset_wake_chk: assert property (@(posedge clk) disable iff (rst)
        drv_reset |=> (mode == 2'd0 && !busy && !irq));

    // R7
    spin_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (spin_req && !spin_done && mode == 2'd0 && !cmd_valid
         && !drv_reset && !tick_1s && !media_req) |=> spin_req);

    // R10
    query_with_irq_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_vld |-> irq);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk i_pwr_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .media_req (media_req),
    .drv_reset (drv_reset),
    .tick_1s   (tick_1s),
    .spin_done (spin_done),
    .mode      (mode),
    .busy      (busy),
    .irq       (irq),
    .spin_req  (spin_req),
    .cnt_vld   (cnt_vld)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic [7:0] sect_cnt = 8'h00;
    logic       media_req = 1'b0;
    logic       drv_reset = 1'b0;
    logic       tick_1s = 1'b0;
    logic       spin_done = 1'b0;
    logic       spin_req, busy, irq, cnt_vld;
    logic [1:0] mode;
    logic [7:0] cnt_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam logic [1:0] M_ACT = 2'd0, M_IDL = 2'd1, M_STB = 2'd2, M_SLP = 2'd3;

    always #2 clk = ~clk;

    pwr_mode_ctrl i_pwr_mode_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .sect_cnt(sect_cnt), .media_req(media_req), .drv_reset(drv_reset),
        .tick_1s(tick_1s), .spin_done(spin_done), .spin_req(spin_req),
        .mode(mode), .busy(busy), .irq(irq), .cnt_o(cnt_o), .cnt_vld(cnt_vld)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [7:0] code, input logic [7:0] cnt);
        cmd_valid = 1'b1; cmd_code = code; sect_cnt = cnt;
        step();
        cmd_valid = 1'b0;
    endtask

    // Power command with full handshake check (R3)
    task automatic pcmd(input logic [7:0] code, input logic [7:0] cnt);
        strobe(code, cnt);
        check("R3 busy", busy, 1);
        step();
        check("R3 irq", {busy, irq}, 2'b01);
        step();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1s = 1'b1; step(); tick_1s = 1'b0; step();
        end
    endtask

    task automatic go_active();
        drv_reset = 1'b1; step(); drv_reset = 1'b0;
        spin_done = 1'b1; step(); spin_done = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 mode", mode, M_ACT);
        check("R1 outs", {busy, irq, spin_req, cnt_vld}, 4'b0000);
        ticks(12);
        check("R1 timer off", mode, M_ACT);
    endtask

    task automatic t_codes();
        go_active();
        pcmd(8'hE1, 0); check("R2 E1 idle", mode, M_IDL);
        go_active();
        pcmd(8'hF8, 0); check("R2 F8 idle", mode, M_IDL);
        pcmd(8'hE0, 0); check("R2 E0 standby", mode, M_STB);
        check("R2 standby no spin", spin_req, 0);
        strobe(8'h20, 0);
        check("R3 other no busy", busy, 0);
        step(); check("R3 other no irq", irq, 0);
    endtask

    task automatic t_ready();
        go_active();
        pcmd(8'hE0, 0);
        strobe(8'hF9, 0);
        check("R8 active", mode, M_ACT);
        check("R8 spin", spin_req, 1);
        step();
        check("R8 irq before spin done", {irq, spin_req}, 2'b11);
        step();
        spin_done = 1'b1; step(); spin_done = 1'b0;
        check("R8 spin cleared", spin_req, 0);
        pcmd(8'hE1, 0);
        pcmd(8'hF9, 0);
        check("R8 from idle active", mode, M_ACT);
        check("R8 from idle no spin", spin_req, 0);
    endtask

    task automatic t_timer();
        go_active();
        pcmd(8'hE3, 8'd1);
        ticks(4); check("R4 before end", mode, M_IDL);
        ticks(1); check("R4 expired", mode, M_STB);
        check("R4 no irq", irq, 0);
        go_active();
        pcmd(8'hE3, 8'd2);
        ticks(9); check("R4 N=2 before", mode, M_IDL);
        ticks(1); check("R4 N=2 expired", mode, M_STB);
    endtask

    task automatic t_zero();
        go_active();
        pcmd(8'hE3, 8'd0);
        ticks(40); check("R5 disabled", mode, M_IDL);
    endtask

    task automatic t_restart();
        go_active();
        pcmd(8'hE3, 8'd1);
        ticks(3);
        strobe(8'h20, 0); step();
        ticks(4); check("R6 restarted", mode, M_IDL);
        ticks(1); check("R6 expired", mode, M_STB);
    endtask

    task automatic t_media();
        go_active();
        pcmd(8'hE0, 0);
        media_req = 1'b1; step(); media_req = 1'b0;
        check("R7 wake", mode, M_ACT);
        check("R7 spin", spin_req, 1);
        step(); step(); step();
        check("R7 spin held", spin_req, 1);
        spin_done = 1'b1; step(); spin_done = 1'b0;
        check("R7 spin done", spin_req, 0);
        pcmd(8'hE1, 0);
        media_req = 1'b1; step(); media_req = 1'b0;
        check("R7 idle to active", {mode, spin_req}, {M_ACT, 1'b0});
    endtask

    task automatic t_query();
        go_active();
        pcmd(8'hE1, 0);
        strobe(8'hE5, 0); step();
        check("R10 idle vld", {cnt_vld, irq}, 2'b11);
        check("R10 idle value", cnt_o, 8'h00);
        step();
        pcmd(8'hF9, 0);
        strobe(8'hE5, 0); step();
        check("R10 active value", cnt_o, 8'hFF);
        step();
        pcmd(8'hE0, 0);
        strobe(8'hE5, 0); step();
        check("R10 standby value", {cnt_vld, cnt_o}, 9'h1FF);
        step();
    endtask

    task automatic t_collide();
        go_active();
        pcmd(8'hE3, 8'd1);
        ticks(4);
        tick_1s = 1'b1; cmd_valid = 1'b1; cmd_code = 8'h20;
        step();
        tick_1s = 1'b0; cmd_valid = 1'b0; step();
        check("R11 command wins", mode, M_IDL);
        ticks(4); check("R11 restarted", mode, M_IDL);
        ticks(1); check("R11 expired later", mode, M_STB);
    endtask

    task automatic t_busy_drop();
        go_active();
        strobe(8'hE0, 0);
        strobe(8'hE6, 0);
        check("R12 irq", irq, 1);
        step(); step();
        check("R12 dropped", mode, M_STB);
    endtask

    task automatic t_sleep();
        go_active();
        pcmd(8'hE6, 0); check("R9 sleep", mode, M_SLP);
        strobe(8'hF9, 0);
        check("R9 cmd ignored", {mode, busy}, {M_SLP, 1'b0});
        step(); check("R9 no irq", irq, 0);
        media_req = 1'b1; step(); media_req = 1'b0;
        check("R9 media ignored", mode, M_SLP);
        drv_reset = 1'b1; step(); drv_reset = 1'b0;
        check("R9 reset wake", {mode, spin_req}, {M_ACT, 1'b1});
        spin_done = 1'b1; step(); spin_done = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_codes();
        t_ready();
        t_timer();
        t_zero();
        t_restart();
        t_media();
        t_query();
        t_collide();
        t_busy_drop();
        t_sleep();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule